// File: doc/BRIEF.md
# Console Input/Output Port Controller

This block sits beside a processor core and owns the console side of two I/O ports: the input port, which receives one word typed by a user, and the output port, whose word is handed to a display. The core signals three kinds of console instruction with single-cycle strobes. The first kind is a non-blocking input request. The second is a blocking input request. The third is an output request. The user side offers words with a valid/data pair.

A non-blocking request arms a one-word capture and lets the core run on. When the word comes, it is written into the input port and a console interrupt request is raised. The request is held until the core acknowledges it. A blocking request stalls the core until a word arrives. That word goes straight into the input port and no interrupt is raised. Words offered when no capture is armed are dropped. All three requests count only while the core is in privileged mode.

Top module: `console_port_ctrl`

## Requirements
- R1: After reset, the input port word, the interrupt request, the stall, the display strobe and the display word are all zero.
- R2: A privileged non-blocking request arms a capture from the next cycle on, without stalling. The first offered word after that loads the input port at the same clock edge and sets the interrupt request.
- R3: A word offered while no capture is armed is discarded. This covers a word offered in the cycle of the arming request itself, and any word after a completed capture. The input port keeps its value and no interrupt is raised.
- R4: A privileged blocking request drives the stall high from the next cycle. The stall stays high until the edge at which a word is taken. That word loads the input port at that edge, the stall is low in the following cycle, and the interrupt request is not raised.
- R5: A further non-blocking request while a capture is already armed keeps the single arming. Only one word is taken and only one interrupt event results.
- R6: The interrupt request stays high until an acknowledge, and clears at the edge after the acknowledge. If a new non-blocking capture completes in the acknowledge cycle, the request stays high.
- R7: A privileged output request gives a one-cycle display strobe in the next cycle. The display word then holds the output-port word sampled with the request, and keeps that word until the next output request.
- R8: Non-blocking, blocking and output requests made while the privilege input is low have no effect.
- R9: A blocking request made while a non-blocking capture is armed converts it into a blocking wait. The stall rises, and the word taken raises no interrupt.
- R10: The interrupt vector output always carries the console vector number, 3 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 1 | Core is in privileged mode |
| in_req_i | input | 1 | Non-blocking input request strobe |
| ini_req_i | input | 1 | Blocking input request strobe |
| out_req_i | input | 1 | Output request strobe |
| p1_i | input | WORD_W | Output port word |
| usr_valid_i | input | 1 | User word offered this cycle |
| usr_data_i | input | WORD_W | User word |
| irq_ack_i | input | 1 | Core acknowledges the console interrupt |
| p0_o | output | WORD_W | Input port word |
| stall_o | output | 1 | Hold the core during a blocking input |
| irq_o | output | 1 | Console interrupt request |
| irq_vec_o | output | VEC_W | Console interrupt vector number |
| disp_valid_o | output | 1 | Display strobe, one cycle |
| disp_word_o | output | WORD_W | Word for the display |

## Verification
A wrong capture state shows up at the ports within one offered word. A stale armed state takes a word that should be dropped, so the input port changes and an interrupt appears. A lost arming leaves the input port unchanged. A blocking wait stuck in the wrong state shows at once as a stall that rises too late or never falls. The reference model in the bench tracks the arming state on its own. Its prediction of the input port, stall, interrupt and display outputs is compared with the design every cycle, so any divergence is reported in the cycle after the edge that caused it. Long waits with no word offered, and acknowledges that land in the same cycle as a capture, are driven on purpose.

// File: rtl/con_pkg.sv
package con_pkg;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_ARMED = 2'd1,
        CS_BLOCK = 2'd2
    } cap_state_e;

endpackage

// File: rtl/con_capture.sv
module con_capture
    import con_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_nb,
    input  logic              arm_blk,
    input  logic              usr_valid,
    input  logic [WORD_W-1:0] usr_data,
    output logic [WORD_W-1:0] p0,
    output logic              stall,
    output logic              got_nb
);

    typedef struct packed {
        cap_state_e        st;
        logic [WORD_W-1:0] p0;
    } cap_t;

    cap_t cap_d, cap_q;
    logic take;

    always_comb begin
        cap_d  = cap_q;
        got_nb = 1'b0;
        take   = usr_valid && (cap_q.st != CS_IDLE);
        if (take) begin
            cap_d.p0 = usr_data;
            cap_d.st = CS_IDLE;
            got_nb   = (cap_q.st == CS_ARMED);
        end
        if (arm_blk) begin
            cap_d.st = CS_BLOCK;
        end else if (arm_nb && (take || cap_q.st == CS_IDLE)) begin
            cap_d.st = CS_ARMED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '{st: CS_IDLE, p0: '0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign p0    = cap_q.p0;
    assign stall = (cap_q.st == CS_BLOCK);

endmodule

// File: rtl/con_irq.sv
module con_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic irq
);

    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (set) begin
            irq_d.pend = 1'b1;
        end else if (ack) begin
            irq_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '{pend: 1'b0};
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q.pend;

endmodule

// File: rtl/con_display.sv
module con_display #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [WORD_W-1:0] word_in,
    output logic              valid,
    output logic [WORD_W-1:0] word_out
);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } disp_t;

    disp_t disp_d, disp_q;

    always_comb begin
        disp_d     = disp_q;
        disp_d.vld = fire;
        if (fire) begin
            disp_d.word = word_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_q <= '{vld: 1'b0, word: '0};
        end else begin
            disp_q <= disp_d;
        end
    end

    assign valid    = disp_q.vld;
    assign word_out = disp_q.word;

endmodule

// File: rtl/console_port_ctrl.sv
module console_port_ctrl #(
    parameter int WORD_W  = 16,
    parameter int VEC_W   = 5,
    parameter int CON_VEC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_i,
    input  logic              in_req_i,
    input  logic              ini_req_i,
    input  logic              out_req_i,
    input  logic [WORD_W-1:0] p1_i,
    input  logic              usr_valid_i,
    input  logic [WORD_W-1:0] usr_data_i,
    input  logic              irq_ack_i,
    output logic [WORD_W-1:0] p0_o,
    output logic              stall_o,
    output logic              irq_o,
    output logic [VEC_W-1:0]  irq_vec_o,
    output logic              disp_valid_o,
    output logic [WORD_W-1:0] disp_word_o
);

    localparam logic [VEC_W-1:0] VecCode = VEC_W'(CON_VEC);

    logic arm_nb, arm_blk, out_fire, got_nb;

    assign arm_nb   = in_req_i  && priv_i;
    assign arm_blk  = ini_req_i && priv_i;
    assign out_fire = out_req_i && priv_i;

    con_capture #(.WORD_W(WORD_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_nb    (arm_nb),
        .arm_blk   (arm_blk),
        .usr_valid (usr_valid_i),
        .usr_data  (usr_data_i),
        .p0        (p0_o),
        .stall     (stall_o),
        .got_nb    (got_nb)
    );

    con_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (got_nb),
        .ack   (irq_ack_i),
        .irq   (irq_o)
    );

    con_display #(.WORD_W(WORD_W)) u_display (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (out_fire),
        .word_in  (p1_i),
        .valid    (disp_valid_o),
        .word_out (disp_word_o)
    );

    assign irq_vec_o = VecCode;

endmodule

// File: rtl/console_port_chk.sv
module console_port_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              priv_i,
    input logic              in_req_i,
    input logic              ini_req_i,
    input logic              out_req_i,
    input logic [WORD_W-1:0] p1_i,
    input logic              usr_valid_i,
    input logic [WORD_W-1:0] usr_data_i,
    input logic              irq_ack_i,
    input logic [WORD_W-1:0] p0_o,
    input logic              stall_o,
    input logic              irq_o,
    input logic              disp_valid_o,
    input logic [WORD_W-1:0] disp_word_o
);

    // R3
    p0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !usr_valid_i |=> $stable(p0_o));

    // R2
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(usr_valid_i));

    // R4
    stall_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && usr_valid_i && !ini_req_i) |=> (!stall_o && p0_o == $past(usr_data_i)));

    // R4
    stall_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !irq_o) |=> !irq_o);

    // R8
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> $past(ini_req_i && priv_i));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_ack_i) |=> irq_o);

    // R7
    disp_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req_i && priv_i) |=> (disp_valid_o && disp_word_o == $past(p1_i)));

    // R7
    disp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_req_i && priv_i) |=> (!disp_valid_o && $stable(disp_word_o)));

endmodule

bind console_port_ctrl console_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .priv_i       (priv_i),
    .in_req_i     (in_req_i),
    .ini_req_i    (ini_req_i),
    .out_req_i    (out_req_i),
    .p1_i         (p1_i),
    .usr_valid_i  (usr_valid_i),
    .usr_data_i   (usr_data_i),
    .irq_ack_i    (irq_ack_i),
    .p0_o         (p0_o),
    .stall_o      (stall_o),
    .irq_o        (irq_o),
    .disp_valid_o (disp_valid_o),
    .disp_word_o  (disp_word_o)
);

// File: tb/console_port_ctrl_bench.sv
`timescale 1ns/1ps
module console_port_ctrl_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         priv = 1'b1;
    logic         in_req = 1'b0, ini_req = 1'b0, out_req = 1'b0;
    logic [W-1:0] p1 = '0;
    logic         uv = 1'b0;
    logic [W-1:0] ud = '0;
    logic         ack = 1'b0;
    logic [W-1:0] p0;
    logic         stall, irq, dv;
    logic [4:0]   vec;
    logic [W-1:0] dw;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    console_port_ctrl u_console_port_ctrl (
        .clk(clk), .rst_n(rst_n), .priv_i(priv), .in_req_i(in_req),
        .ini_req_i(ini_req), .out_req_i(out_req), .p1_i(p1),
        .usr_valid_i(uv), .usr_data_i(ud), .irq_ack_i(ack),
        .p0_o(p0), .stall_o(stall), .irq_o(irq), .irq_vec_o(vec),
        .disp_valid_o(dv), .disp_word_o(dw)
    );

    // Reference model: 0 idle, 1 waiting with interrupt, 2 waiting with stall
    int           m_mode = 0;
    logic [W-1:0] m_p0 = '0;
    logic         m_irq = 1'b0;
    logic         m_dv = 1'b0;
    logic [W-1:0] m_dw = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_p0 = '0; m_irq = 1'b0; m_dv = 1'b0; m_dw = '0;
        end else begin
            bit got, raise;
            got = uv && (m_mode != 0);
            raise = got && (m_mode == 1);
            if (got) begin
                m_p0 = ud;
                m_mode = 0;
            end
            if (ini_req && priv) m_mode = 2;
            else if (in_req && priv && m_mode == 0) m_mode = 1;
            if (raise) m_irq = 1'b1;
            else if (ack) m_irq = 1'b0;
            m_dv = out_req && priv;
            if (out_req && priv) m_dw = p1;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 p0 vs model", p0, m_p0);
            chk("R6 irq vs model", W'(irq), W'(m_irq));
            chk("R4 stall vs model", W'(stall), W'(m_mode == 2));
            chk("R7 strobe vs model", W'(dv), W'(m_dv));
            chk("R7 word vs model", dw, m_dw);
        end
    end

    task automatic tick();
        @(negedge clk);
        in_req = 0; ini_req = 0; out_req = 0; uv = 0; ack = 0;
    endtask

    task automatic offer(input logic [W-1:0] d);
        uv = 1; ud = d; tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 p0", p0, '0);
        chk("R1 irq", W'(irq), '0);
        chk("R1 stall", W'(stall), '0);
        chk("R1 disp", W'(dv), '0);
        chk("R1 word", dw, '0);
        // R10 vector
        chk("R10 vec", W'(vec), 16'd3);
        rst_n = 1;
        tick();

        // R3 unarmed word dropped
        offer(16'hA5A5);
        chk("R3 idle word p0", p0, '0);
        chk("R3 idle word irq", W'(irq), '0);

        // R2 non-blocking capture
        in_req = 1; tick();
        tick(); tick();
        chk("R2 no stall", W'(stall), '0);
        offer(16'h1234);
        chk("R2 p0 loaded", p0, 16'h1234);
        chk("R2 irq set", W'(irq), 16'd1);

        // R3 after capture
        offer(16'h7777);
        chk("R3 after capture", p0, 16'h1234);

        // R6 held until ack
        repeat (4) tick();
        chk("R6 held", W'(irq), 16'd1);
        ack = 1; tick();
        chk("R6 cleared", W'(irq), '0);

        // R3 word same cycle as arming
        in_req = 1; uv = 1; ud = 16'hBEEF; tick();
        chk("R3 same cycle", p0, 16'h1234);
        offer(16'h2222);
        chk("R3 armed takes next", p0, 16'h2222);
        ack = 1; tick();

        // R5 repeated arming
        in_req = 1; tick();
        in_req = 1; tick();
        in_req = 1; tick();
        offer(16'h4444);
        chk("R5 first word", p0, 16'h4444);
        ack = 1; tick();
        offer(16'h5555);
        chk("R5 single capture p0", p0, 16'h4444);
        chk("R5 single capture irq", W'(irq), '0);

        // R4 blocking wait
        ini_req = 1; tick();
        chk("R4 stall up", W'(stall), 16'd1);
        repeat (3) tick();
        chk("R4 stall held", W'(stall), 16'd1);
        offer(16'h6666);
        chk("R4 stall down", W'(stall), '0);
        chk("R4 p0 loaded", p0, 16'h6666);
        chk("R4 no irq", W'(irq), '0);

        // R8 unprivileged requests
        priv = 0;
        in_req = 1; tick();
        offer(16'h8888);
        chk("R8 in ignored", p0, 16'h6666);
        ini_req = 1; tick();
        chk("R8 ini ignored", W'(stall), '0);
        p1 = 16'h1111; out_req = 1; tick();
        chk("R8 out ignored", W'(dv), '0);
        priv = 1;

        // R7 output
        p1 = 16'hABCD; out_req = 1; tick();
        chk("R7 strobe", W'(dv), 16'd1);
        chk("R7 word", dw, 16'hABCD);
        p1 = 16'h0F0F; tick();
        chk("R7 single pulse", W'(dv), '0);
        chk("R7 word kept", dw, 16'hABCD);

        // R9 blocking converts armed capture
        in_req = 1; tick();
        ini_req = 1; tick();
        chk("R9 stall", W'(stall), 16'd1);
        offer(16'h9999);
        chk("R9 p0", p0, 16'h9999);
        chk("R9 no irq", W'(irq), '0);

        // R6 ack in same cycle as a new capture
        in_req = 1; tick();
        offer(16'h0101);
        in_req = 1; tick();
        uv = 1; ud = 16'h0202; ack = 1; tick();
        chk("R6 set beats ack", W'(irq), 16'd1);
        chk("R6 p0", p0, 16'h0202);
        ack = 1; tick();

        // Mixed traffic against the model
        for (int i = 0; i < 2000; i++) begin
            priv    = ($urandom_range(0, 7) != 0);
            in_req  = ($urandom_range(0, 5) == 0);
            ini_req = ($urandom_range(0, 11) == 0);
            out_req = ($urandom_range(0, 3) == 0);
            uv      = ($urandom_range(0, 3) == 0);
            ud      = W'($urandom);
            p1      = W'($urandom);
            ack     = ($urandom_range(0, 4) == 0);
            @(negedge clk);
        end
        tick();
        finish_run();
    end

endmodule